// File: doc/BRIEF.md
# Programmable Interrupt Controller Core

This block collects eight edge-triggered interrupt request lines. It ranks them by fixed priority and raises one interrupt line toward a processor. When the processor acknowledges, the block returns an 8-bit vector that identifies the winning input. The processor reaches the block through a small register port: a one-bit address, a write strobe, an 8-bit write bus and a combinational read bus.

Software must first send a four-word setup sequence, which is steered by the address bit. An address-0 write with bit 4 set opens the sequence. Three address-1 words follow, in this order: the vector base, the cascade configuration word and the mode word. After setup, address-1 writes load the mask register. Address-0 writes carry commands: end of interrupt, and the choice of which internal register the address-0 read shows. The cascade word has no effect on interrupt flow; software can only read it back. Setup can be restarted at any time.

Top module: `irq_ctrl_core`

## Requirements
- R1: After reset, and in the cycle after any setup-opening write, the mask is 0xFF, the pending and in-service registers are zero, the address-0 read shows pending, and `int_out` is low.
- R2: An address-0 write with data bit 4 set opens setup at any time, even in the middle of a sequence. It discards the partial sequence and clears any pending and in-service bits.
- R3: Setup takes three address-1 writes after the opening word, in strict order. The first supplies the vector base in bits 7:3, the second the cascade word, and the third the mode word, where bit 1 = 1 selects automatic end of interrupt. Until the third word arrives, address-1 writes never change the mask, and address-0 writes without bit 4 are ignored.
- R4: After command 0x0C is written at address 0, an address-0 read returns the stored cascade word.
- R5: A rising edge on `irq_in[i]` sets pending bit i. A line held high after its request was acknowledged does not set the bit again.
- R6: Priority is fixed, with input 0 highest. `int_out` is high exactly when setup is complete and some unmasked pending input has a higher priority than every in-service input.
- R7: While `inta` is high and `int_out` is high, `vector_out` equals base × 8 + winning index. At the following edge the winner's pending bit clears, and its in-service bit sets when normal end of interrupt is selected.
- R8: With automatic end of interrupt, an acknowledge leaves the in-service register unchanged.
- R9: Command 0x20 at address 0 clears the highest-priority set in-service bit.
- R10: After setup, an address-1 write loads the mask. A masked input still records pending and asserts `int_out` once its mask bit is cleared. This supports mask-then-end-of-interrupt ordering.
- R11: An address-1 read returns the mask. After command 0x0A the address-0 read returns pending, and after command 0x0B it returns in-service.
- R12: An acknowledge while `int_out` is low yields base × 8 + 7 and changes neither pending nor in-service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 1 | Register port address bit |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data selected by `addr` |
| irq_in | input | 8 | Interrupt request lines, rising-edge sensitive |
| int_out | output | 1 | Interrupt request to the processor |
| inta | input | 1 | Acknowledge pulse from the processor |
| vector_out | output | 8 | Vector, valid while `inta` is high |

## Verification
A single request, first masked and then unmasked, shows that pending capture is separate from output gating. Two requests raised together, followed by a higher-priority request during service, check the fixed ordering and nesting against the in-service register. A line held high across its acknowledge distinguishes edge capture from level capture. The sequence of masking, then end of interrupt, then re-raising the line shows that a masked input is held rather than lost. A second setup that is restarted midway, with a new base and automatic end of interrupt, checks the restart, the vector arithmetic and the mode word together. An acknowledge with nothing pending checks the fallback vector.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  localparam int unsigned DATA_W = 8;

  typedef enum logic [2:0] {
    CFG_IDLE,
    CFG_BASE,
    CFG_CASC,
    CFG_MODE,
    CFG_RUN
  } cfg_state_e;

  typedef enum logic [1:0] {
    RSEL_PEND,
    RSEL_ISR,
    RSEL_CASC
  } rd_sel_e;

  localparam logic [DATA_W-1:0] CMD_EOI       = 8'h20;
  localparam logic [DATA_W-1:0] CMD_READ_PEND = 8'h0A;
  localparam logic [DATA_W-1:0] CMD_READ_ISR  = 8'h0B;
  localparam logic [DATA_W-1:0] CMD_READ_CASC = 8'h0C;

  localparam int unsigned OPEN_BIT     = 4;
  localparam int unsigned AUTO_EOI_BIT = 1;

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int unsigned N_IRQ = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] lines,
  output logic [N_IRQ-1:0] rise
);
  logic [N_IRQ-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lines;
  end

  genvar g;
  generate
    for (g = 0; g < N_IRQ; g++) begin : g_edge
      assign rise[g] = lines[g] & ~prev_q[g];
    end
  endgenerate
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned N_IRQ = 8,
  localparam int unsigned IDX_W = $clog2(N_IRQ)
) (
  input  logic [N_IRQ-1:0] req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_init_fsm.sv
module irq_init_fsm
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned BASE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              open_wr,
  output logic              ready,
  output logic [BASE_W-1:0] base_q,
  output logic [DATA_W-1:0] casc_q,
  output logic              auto_eoi_q
);
  cfg_state_e        state_q, state_d;
  logic [BASE_W-1:0] base_d;
  logic [DATA_W-1:0] casc_d;
  logic              auto_d;
  logic              word_wr;

  assign open_wr = wr_en && !addr && wdata[OPEN_BIT];
  assign word_wr = wr_en && addr;
  assign ready   = (state_q == CFG_RUN);

  always_comb begin
    state_d = state_q;
    base_d  = base_q;
    casc_d  = casc_q;
    auto_d  = auto_eoi_q;
    if (open_wr) begin
      state_d = CFG_BASE;
    end else if (word_wr) begin
      unique case (state_q)
        CFG_BASE: begin
          base_d  = wdata[DATA_W-1 -: BASE_W];
          state_d = CFG_CASC;
        end
        CFG_CASC: begin
          casc_d  = wdata;
          state_d = CFG_MODE;
        end
        CFG_MODE: begin
          auto_d  = wdata[AUTO_EOI_BIT];
          state_d = CFG_RUN;
        end
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= CFG_IDLE;
      base_q     <= '0;
      casc_q     <= '0;
      auto_eoi_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      base_q     <= base_d;
      casc_q     <= casc_d;
      auto_eoi_q <= auto_d;
    end
  end
endmodule

// File: rtl/irq_ctrl_core.sv
module irq_ctrl_core
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned N_IRQ = 8,
  localparam int unsigned IDX_W  = $clog2(N_IRQ),
  localparam int unsigned BASE_W = DATA_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [N_IRQ-1:0]  irq_in,
  output logic              int_out,
  input  logic              inta,
  output logic [DATA_W-1:0] vector_out
);
  logic              rst_n_sync;
  logic              open_wr, ready, auto_eoi;
  logic [BASE_W-1:0] base_q;
  logic [DATA_W-1:0] casc_q;
  logic [N_IRQ-1:0]  rise;
  logic [N_IRQ-1:0]  mask_q, mask_d, pend_q, pend_d, isr_q, isr_d;
  rd_sel_e           rsel_q, rsel_d;
  logic              req_any, isr_any;
  logic [IDX_W-1:0]  req_idx, isr_idx;
  logic              ack_take, cmd_wr, eoi_wr, mask_wr;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  irq_init_fsm #(.BASE_W(BASE_W)) u_cfg (
    .clk(clk), .rst_n(rst_n_sync), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .open_wr(open_wr), .ready(ready), .base_q(base_q),
    .casc_q(casc_q), .auto_eoi_q(auto_eoi)
  );

  irq_edge_detect #(.N_IRQ(N_IRQ)) u_edge (
    .clk(clk), .rst_n(rst_n_sync), .lines(irq_in), .rise(rise)
  );

  irq_prio_pick #(.N_IRQ(N_IRQ)) u_pick_req (
    .req(pend_q & ~mask_q), .any(req_any), .idx(req_idx)
  );

  irq_prio_pick #(.N_IRQ(N_IRQ)) u_pick_isr (
    .req(isr_q), .any(isr_any), .idx(isr_idx)
  );

  assign int_out  = ready && req_any && (!isr_any || (req_idx < isr_idx));
  assign ack_take = inta && int_out;
  assign cmd_wr   = ready && wr_en && !addr && !wdata[OPEN_BIT];
  assign eoi_wr   = cmd_wr && (wdata == CMD_EOI);
  assign mask_wr  = ready && wr_en && addr;

  assign vector_out = !inta     ? '0 :
                      ack_take  ? {base_q, req_idx} :
                                  {base_q, {IDX_W{1'b1}}};

  always_comb begin
    mask_d = mask_q;
    pend_d = pend_q;
    isr_d  = isr_q;
    rsel_d = rsel_q;
    if (open_wr) begin
      mask_d = '1;
      pend_d = '0;
      isr_d  = '0;
      rsel_d = RSEL_PEND;
    end else begin
      if (mask_wr) mask_d = wdata[N_IRQ-1:0];
      if (ack_take) pend_d[req_idx] = 1'b0;
      pend_d = pend_d | rise;
      if (eoi_wr && isr_any) isr_d[isr_idx] = 1'b0;
      if (ack_take && !auto_eoi) isr_d[req_idx] = 1'b1;
      if (cmd_wr) begin
        if (wdata == CMD_READ_PEND) rsel_d = RSEL_PEND;
        if (wdata == CMD_READ_ISR)  rsel_d = RSEL_ISR;
        if (wdata == CMD_READ_CASC) rsel_d = RSEL_CASC;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      mask_q <= '1;
      pend_q <= '0;
      isr_q  <= '0;
      rsel_q <= RSEL_PEND;
    end else begin
      mask_q <= mask_d;
      pend_q <= pend_d;
      isr_q  <= isr_d;
      rsel_q <= rsel_d;
    end
  end

  always_comb begin
    if (addr) begin
      rdata = DATA_W'(mask_q);
    end else begin
      unique case (rsel_q)
        RSEL_ISR:  rdata = DATA_W'(isr_q);
        RSEL_CASC: rdata = casc_q;
        default:   rdata = DATA_W'(pend_q);
      endcase
    end
  end
endmodule

// File: rtl/irq_ctrl_checker.sv
module irq_ctrl_checker #(
  parameter int unsigned N_IRQ = 8
) (
  input logic             clk,
  input logic             rst_n_sync,
  input logic             addr,
  input logic             wr_en,
  input logic [7:0]       wdata,
  input logic             inta,
  input logic             int_out,
  input logic             ready,
  input logic             auto_eoi,
  input logic [N_IRQ-1:0] mask_q,
  input logic [N_IRQ-1:0] pend_q,
  input logic [N_IRQ-1:0] isr_q
);
  p_open_clears_r1: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (wr_en && !addr && wdata[4]) |=> (mask_q == '1 && pend_q == '0 && isr_q == '0 && !int_out));

  p_no_mask_in_setup_r3: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!ready && wr_en && addr) |=> $stable(mask_q));

  p_out_needs_unmasked_r6: assert property (@(posedge clk) disable iff (!rst_n_sync)
    int_out |-> ((pend_q & ~mask_q) != '0 && ready));

  p_auto_keeps_isr_r8: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (inta && int_out && auto_eoi && !wr_en) |=> $stable(isr_q));

  p_eoi_drops_one_r9: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (ready && wr_en && !addr && wdata == 8'h20 && isr_q != '0 && !inta)
      |=> ($countones(isr_q) + 1 == $countones($past(isr_q))));

  p_spurious_no_change_r12: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (inta && !int_out && !wr_en) |=> $stable(isr_q));
endmodule

bind irq_ctrl_core irq_ctrl_checker #(.N_IRQ(N_IRQ)) u_chk (
  .clk(clk), .rst_n_sync(rst_n_sync), .addr(addr), .wr_en(wr_en),
  .wdata(wdata), .inta(inta), .int_out(int_out), .ready(ready),
  .auto_eoi(auto_eoi), .mask_q(mask_q), .pend_q(pend_q), .isr_q(isr_q)
);

// File: tb/irq_ctrl_core_test.sv
module irq_ctrl_core_test;
  logic       clk = 1'b0;
  logic       rst_n, addr, wr_en, inta, int_out;
  logic [7:0] wdata, rdata, irq_in, vector_out;
  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  irq_ctrl_core uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .irq_in(irq_in), .int_out(int_out), .inta(inta),
    .vector_out(vector_out)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic rd_sel(input logic [7:0] cmd, output logic [7:0] d);
    wr(1'b0, cmd); rd(1'b0, d);
  endtask

  task automatic set_lines(input logic [7:0] v);
    @(negedge clk); irq_in = v;
    @(negedge clk);
  endtask

  task automatic ack(output logic [7:0] v);
    @(negedge clk); inta = 1'b1; #1; v = vector_out;
    @(negedge clk); inta = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 int_out after reset", {7'd0, int_out}, 8'h00);
    rd(1'b1, d); chk("R1 mask after reset", d, 8'hFF);
    rd(1'b0, d); chk("R1 pending after reset", d, 8'h00);
  endtask

  task automatic t_setup;
    logic [7:0] d;
    wr(1'b0, 8'h11);
    wr(1'b1, 8'h20);
    wr(1'b0, 8'h20);           // R3 ignored during setup
    wr(1'b1, 8'h04);
    rd(1'b1, d); chk("R3 mask untouched by setup words", d, 8'hFF);
    wr(1'b1, 8'h01);
    rd(1'b1, d); chk("R1 mask all set after setup", d, 8'hFF);
    rd_sel(8'h0C, d); chk("R4 cascade word read back", d, 8'h04);
  endtask

  task automatic t_single;
    logic [7:0] d, v;
    set_lines(8'h08);
    chk("R10 masked input keeps int_out low", {7'd0, int_out}, 8'h00);
    rd_sel(8'h0A, d); chk("R5 pending set by edge while masked", d, 8'h08);
    wr(1'b1, 8'h00);
    chk("R10 unmask raises int_out", {7'd0, int_out}, 8'h01);
    ack(v); chk("R7 vector for input 3", v, 8'h23);
    chk("R6 int_out low while 3 in service", {7'd0, int_out}, 8'h00);
    rd_sel(8'h0B, d); chk("R11 in-service read", d, 8'h08);
    wr(1'b0, 8'h20);
    rd(1'b0, d); chk("R9 EOI clears in-service", d, 8'h00);
    set_lines(8'h00);
  endtask

  task automatic t_priority;
    logic [7:0] d, v;
    set_lines(8'h24);
    ack(v); chk("R6 input 2 beats 5", v, 8'h22);
    chk("R6 lower 5 blocked by 2 in service", {7'd0, int_out}, 8'h00);
    set_lines(8'h26);
    chk("R6 input 1 nests over 2", {7'd0, int_out}, 8'h01);
    ack(v); chk("R7 vector for input 1", v, 8'h21);
    rd_sel(8'h0B, d); chk("R7 nested in-service", d, 8'h06);
    wr(1'b0, 8'h20);
    rd(1'b0, d); chk("R9 EOI clears highest (1)", d, 8'h04);
    chk("R6 5 still blocked by 2", {7'd0, int_out}, 8'h00);
    wr(1'b0, 8'h20);
    chk("R6 5 released after EOI", {7'd0, int_out}, 8'h01);
    ack(v); chk("R7 vector for input 5", v, 8'h25);
    rd_sel(8'h0A, d); chk("R5 held lines do not re-pend", d, 8'h00);
    wr(1'b0, 8'h20);
    set_lines(8'h00);
    chk("R5 no request after lines drop", {7'd0, int_out}, 8'h00);
  endtask

  task automatic t_mask_ack;
    logic [7:0] d, v;
    set_lines(8'h10);
    ack(v); chk("R7 vector for input 4", v, 8'h24);
    wr(1'b1, 8'h10);
    wr(1'b0, 8'h20);
    rd_sel(8'h0B, d); chk("R10 EOI after mask clears in-service", d, 8'h00);
    set_lines(8'h00);
    set_lines(8'h10);
    chk("R10 masked re-raise stays quiet", {7'd0, int_out}, 8'h00);
    rd_sel(8'h0A, d); chk("R10 masked re-raise pending", d, 8'h10);
    wr(1'b1, 8'h00);
    chk("R10 unmask releases held request", {7'd0, int_out}, 8'h01);
    ack(v); chk("R7 vector for input 4 again", v, 8'h24);
    wr(1'b0, 8'h20);
    set_lines(8'h00);
  endtask

  task automatic t_spurious;
    logic [7:0] d, v;
    chk("R12 idle int_out low", {7'd0, int_out}, 8'h00);
    ack(v); chk("R12 fallback vector", v, 8'h27);
    rd_sel(8'h0B, d); chk("R12 in-service unchanged", d, 8'h00);
    rd_sel(8'h0A, d); chk("R12 pending unchanged", d, 8'h00);
  endtask

  task automatic t_reinit;
    logic [7:0] d, v;
    wr(1'b1, 8'hFF);
    set_lines(8'h01);
    set_lines(8'h00);
    rd(1'b0, d); chk("R5 pending before restart", d, 8'h01);
    wr(1'b0, 8'h11);
    rd(1'b0, d); chk("R2 restart clears pending", d, 8'h00);
    wr(1'b1, 8'h30);
    wr(1'b0, 8'h13);           // R2 restart mid-sequence
    wr(1'b1, 8'h28);
    rd(1'b1, d); chk("R3 base word is not a mask write", d, 8'hFF);
    wr(1'b1, 8'h02);
    wr(1'b1, 8'h03);
    wr(1'b1, 8'h00);
    set_lines(8'h40);
    ack(v); chk("R2 new base after restart", v, 8'h2E);
    rd_sel(8'h0B, d); chk("R8 auto EOI leaves in-service empty", d, 8'h00);
    chk("R8 no request after auto EOI ack", {7'd0, int_out}, 8'h00);
    set_lines(8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; addr = 1'b0; wr_en = 1'b0; wdata = '0; inta = 1'b0; irq_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_setup();
    t_single();
    t_priority();
    t_mask_ack();
    t_spurious();
    t_reinit();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule